// File: doc/BRIEF.md
# Display Blink and Dimming Blank Generator

This block drives a single active-low blank line for a character display controller. The line is pulled low to darken the whole display. It only gates the illumination, so pulsing it leaves character and cursor memory untouched. It has two modes. In flash mode it produces a slow square wave with equal dark and lit halves, so the display blinks at a selectable rate between 1 Hz and 10 Hz. In dim mode it produces a fast pulse train with a fixed period. The default period is 200 µs (5 kHz), well above the 2.5 kHz floor. The dark time inside each period sets the apparent brightness.

All timing comes from the system clock. A prescaler divides the clock into base ticks, 1 µs each by default. A period counter then counts those ticks. The mode, rate and duty inputs are captured only when a new period begins, so a change made mid-period never cuts a pulse short. A dim duty outside the allowed window is clamped to the nearest limit. While the block is disabled, the display stays lit.

Top module: `blankGen`

## Requirements
- R1: During and right after reset, `blankN` is 1.
- R2: At the first clock edge where `enable` is sampled 0, `blankN` becomes 1. It stays 1 for as long as `enable` remains 0.
- R3: When `enable` is first sampled 1 while idle, that edge starts a period. `blankN` goes to 0 on the following edge.
- R4: In dim mode (`dimMode`=1), each period lasts DIM_PERIOD ticks. `blankN` is 0 for the first D ticks of the period and 1 for the rest, where D is `dimDuty` after clamping. One tick is TICK_DIV clocks.
- R5: A `dimDuty` below DIM_MIN gives a dark time of DIM_MIN ticks.
- R6: A `dimDuty` above DIM_MAX gives a dark time of DIM_MAX ticks.
- R7: In flash mode (`dimMode`=0), the dark and lit halves each last H = FLASH_HALF_BASE / r ticks, using integer division. Here r is `flashRate` read as Hz.
- R8: A `flashRate` of 0 is treated as 1. A value above RATE_MAX is treated as RATE_MAX.
- R9: A change to `dimDuty`, `flashRate` or `dimMode` while the block runs takes effect only at the next period start. The current dark or lit phase keeps its old length.
- R10: Outside of a disable, no dark or lit phase is shorter than the smallest length the settings allow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; 0 keeps the display lit |
| dimMode | input | 1 | 1 selects dimming, 0 selects blinking |
| flashRate | input | RATE_W | Blink rate in Hz |
| dimDuty | input | DUTY_W | Dark ticks per dim period |
| blankN | output | 1 | Active-low blank line |

## Verification
The minimum-width checks assume that a phase is cut short only when `enable` drops. They also assume that reset is not applied mid-run without a matching disable. Every test therefore changes settings during a running period, or restarts through a disable of a few cycles, and never pulses reset after start. The bench uses a reduced configuration: 2 clocks per tick, a 20-tick dim period with limits of 2 and 18, and a 60-tick base half-period. With these values every duty code and every rate code can be swept and the phase lengths predicted by integer arithmetic.

// File: rtl/blankGenPkg.sv
package blankGenPkg;

  typedef enum logic {
    MODE_FLASH = 1'b0,
    MODE_DIM   = 1'b1
  } blankMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;      // generator active this cycle
    logic load;     // start a new period and capture settings
    logic advance;  // step the period position by one tick
  } ctrlStrobe_t;

endpackage

// File: rtl/blankCtrl.sv
module blankCtrl
  import blankGenPkg::*;
#(
  parameter int TICK_DIV = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        periodEnd,
  output ctrlStrobe_t strobe
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic             preWrap;
  logic             tick;

  assign preWrap = (preCnt == PRE_LAST);

  always_comb begin
    strobe.run     = running & enable;
    tick           = strobe.run & preWrap;
    strobe.load    = (enable & ~running) | (tick & periodEnd);
    strobe.advance = tick & ~periodEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt  <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      preCnt  <= '0;
    end else begin
      running <= 1'b1;
      if (!running || preWrap) preCnt <= '0;
      else                     preCnt <= preCnt + PRE_W'(1);
    end
  end

endmodule

// File: rtl/blankPath.sv
module blankPath
  import blankGenPkg::*;
#(
  parameter int DIM_PERIOD      = 200,
  parameter int DIM_MIN         = 4,
  parameter int DIM_MAX         = 196,
  parameter int FLASH_HALF_BASE = 500000,
  parameter int RATE_MAX        = 10,
  parameter int RATE_W          = 4,
  parameter int DUTY_W          = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dimMode,
  input  logic [RATE_W-1:0] flashRate,
  input  logic [DUTY_W-1:0] dimDuty,
  input  ctrlStrobe_t       strobe,
  output logic              periodEnd,
  output logic              blankN
);

  localparam int MAX_LEN    = (2 * FLASH_HALF_BASE > DIM_PERIOD) ? 2 * FLASH_HALF_BASE : DIM_PERIOD;
  localparam int POS_W      = $clog2(MAX_LEN + 1);
  localparam int RATE_SLOTS = 1 << RATE_W;

  function automatic int clampRate(input int r);
    if (r < 1)        return 1;
    if (r > RATE_MAX) return RATE_MAX;
    return r;
  endfunction

  // Half-period length for every rate code, fixed at elaboration
  logic [POS_W-1:0] halfTab [RATE_SLOTS];
  for (genvar g = 0; g < RATE_SLOTS; g++) begin : gHalf
    assign halfTab[g] = POS_W'(FLASH_HALF_BASE / clampRate(g));
  end

  logic [DUTY_W-1:0] dutyClamped;
  logic [POS_W-1:0]  halfSel;
  logic [POS_W-1:0]  nextLow;
  logic [POS_W-1:0]  nextLast;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  lowLen;
  logic [POS_W-1:0]  lastPos;

  always_comb begin
    if (dimDuty < DUTY_W'(DIM_MIN))      dutyClamped = DUTY_W'(DIM_MIN);
    else if (dimDuty > DUTY_W'(DIM_MAX)) dutyClamped = DUTY_W'(DIM_MAX);
    else                                 dutyClamped = dimDuty;
  end

  assign halfSel = halfTab[flashRate];

  always_comb begin
    if (blankMode_e'(dimMode) == MODE_DIM) begin
      nextLow  = POS_W'(dutyClamped);
      nextLast = POS_W'(DIM_PERIOD - 1);
    end else begin
      nextLow  = halfSel;
      nextLast = (halfSel << 1) - POS_W'(1);
    end
  end

  assign periodEnd = (pos == lastPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      lowLen  <= '0;
      lastPos <= '0;
    end else if (strobe.load) begin
      pos     <= '0;
      lowLen  <= nextLow;
      lastPos <= nextLast;
    end else if (strobe.advance) begin
      pos <= pos + POS_W'(1);
    end else if (!strobe.run) begin
      pos <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blankN <= 1'b1;
    else       blankN <= ~(strobe.run & (pos < lowLen));
  end

endmodule

// File: rtl/blankGen.sv
module blankGen
  import blankGenPkg::*;
#(
  parameter int TICK_DIV        = 250,
  parameter int DIM_PERIOD      = 200,
  parameter int DIM_MIN         = 4,
  parameter int DIM_MAX         = 196,
  parameter int FLASH_HALF_BASE = 500000,
  parameter int RATE_MAX        = 10,
  parameter int RATE_W          = 4,
  parameter int DUTY_W          = $clog2(DIM_PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              dimMode,
  input  logic [RATE_W-1:0] flashRate,
  input  logic [DUTY_W-1:0] dimDuty,
  output logic              blankN
);

  ctrlStrobe_t strobe;
  logic        periodEnd;

  blankCtrl #(.TICK_DIV(TICK_DIV)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .periodEnd(periodEnd),
    .strobe   (strobe)
  );

  blankPath #(
    .DIM_PERIOD     (DIM_PERIOD),
    .DIM_MIN        (DIM_MIN),
    .DIM_MAX        (DIM_MAX),
    .FLASH_HALF_BASE(FLASH_HALF_BASE),
    .RATE_MAX       (RATE_MAX),
    .RATE_W         (RATE_W),
    .DUTY_W         (DUTY_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .dimMode  (dimMode),
    .flashRate(flashRate),
    .dimDuty  (dimDuty),
    .strobe   (strobe),
    .periodEnd(periodEnd),
    .blankN   (blankN)
  );

endmodule

// File: rtl/blankGenChecker.sv
module blankGenChecker #(
  parameter int TICK_DIV        = 250,
  parameter int DIM_PERIOD      = 200,
  parameter int DIM_MIN         = 4,
  parameter int DIM_MAX         = 196,
  parameter int FLASH_HALF_BASE = 500000,
  parameter int RATE_MAX        = 10
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic blankN
);

  localparam int MIN_HALF = FLASH_HALF_BASE / RATE_MAX;
  localparam int DIM_LIT  = DIM_PERIOD - DIM_MAX;
  localparam int MIN_LOW  = ((DIM_MIN < MIN_HALF) ? DIM_MIN : MIN_HALF) * TICK_DIV;
  localparam int MIN_HIGH = ((DIM_LIT < MIN_HALF) ? DIM_LIT : MIN_HALF) * TICK_DIV;

  int   lowRun;
  int   highRun;
  logic prevBlank;
  logic prevEn;
  logic natHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun    <= 0;
      highRun   <= 0;
      prevBlank <= 1'b1;
      prevEn    <= 1'b0;
      natHigh   <= 1'b0;
    end else begin
      prevBlank <= blankN;
      prevEn    <= enable;
      lowRun    <= blankN ? 0 : lowRun + 1;
      highRun   <= blankN ? highRun + 1 : 0;
      if (!enable || !blankN)                  natHigh <= 1'b0;
      else if (blankN && !prevBlank && prevEn) natHigh <= 1'b1;
    end
  end

  AST_RESET_LIT: assert property (@(posedge clk) !rstN |=> blankN); // R1
  AST_DISABLED_LIT: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> blankN); // R2
  AST_MIN_DARK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(blankN) && $past(enable)) |-> (lowRun >= MIN_LOW)); // R10
  AST_MIN_LIT: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(blankN) && natHigh) |-> (highRun >= MIN_HIGH)); // R10
  AST_KNOWN_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(blankN)); // R1

endmodule

bind blankGen blankGenChecker #(
  .TICK_DIV       (TICK_DIV),
  .DIM_PERIOD     (DIM_PERIOD),
  .DIM_MIN        (DIM_MIN),
  .DIM_MAX        (DIM_MAX),
  .FLASH_HALF_BASE(FLASH_HALF_BASE),
  .RATE_MAX       (RATE_MAX)
) uChecker (
  .clk   (clk),
  .rstN  (rstN),
  .enable(enable),
  .blankN(blankN)
);

// File: tb/tb_blankGen.sv
module tb_blankGen;

  localparam int TICK_DIV   = 2;
  localparam int DIM_PERIOD = 20;
  localparam int DIM_MIN    = 2;
  localparam int DIM_MAX    = 18;
  localparam int HALF_BASE  = 60;
  localparam int RATE_MAX   = 10;
  localparam int RATE_W     = 4;
  localparam int DUTY_W     = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              dimMode = 1'b1;
  logic [RATE_W-1:0] flashRate = '0;
  logic [DUTY_W-1:0] dimDuty = '0;
  logic              blankN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  blankGen #(
    .TICK_DIV(TICK_DIV), .DIM_PERIOD(DIM_PERIOD), .DIM_MIN(DIM_MIN),
    .DIM_MAX(DIM_MAX), .FLASH_HALF_BASE(HALF_BASE), .RATE_MAX(RATE_MAX),
    .RATE_W(RATE_W), .DUTY_W(DUTY_W)
  ) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .dimMode(dimMode),
    .flashRate(flashRate), .dimDuty(dimDuty), .blankN(blankN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expDuty(input int d);
    if (d < DIM_MIN) return DIM_MIN;
    if (d > DIM_MAX) return DIM_MAX;
    return d;
  endfunction

  function automatic int expHalf(input int r);
    int c;
    c = (r < 1) ? 1 : ((r > RATE_MAX) ? RATE_MAX : r);
    return HALF_BASE / c;
  endfunction

  task automatic restart();
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic countLow(output int n);
    n = 0;
    while (!blankN) begin n++; @(negedge clk); end
  endtask

  task automatic countHigh(output int n);
    n = 0;
    while (blankN) begin n++; @(negedge clk); end
  endtask

  task automatic waitDark();
    @(negedge clk);
    while (blankN) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lowC, highC, bad;
    repeat (3) @(negedge clk);
    check("R1 during reset", int'(blankN), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", int'(blankN), 1);

    // R3: start latency
    dimDuty = 5'd5;
    dimMode = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R3 lit one edge after enable", int'(blankN), 1);
    @(negedge clk);
    check("R3 dark two edges after enable", int'(blankN), 0);

    // R4 R5 R6: every duty code
    for (int d = 0; d < (1 << DUTY_W); d++) begin
      dimDuty = DUTY_W'(d);
      restart();
      waitDark();
      countLow(lowC);
      countHigh(highC);
      check(d < DIM_MIN ? "R5 dark clamp" : (d > DIM_MAX ? "R6 dark clamp" : "R4 dark"),
            lowC, expDuty(d) * TICK_DIV);
      check("R4 lit", highC, (DIM_PERIOD - expDuty(d)) * TICK_DIV);
    end

    // R7 R8: every rate code
    dimMode = 1'b0;
    for (int r = 0; r < (1 << RATE_W); r++) begin
      flashRate = RATE_W'(r);
      restart();
      waitDark();
      countLow(lowC);
      countHigh(highC);
      check((r < 1 || r > RATE_MAX) ? "R8 rate clamp dark" : "R7 flash dark",
            lowC, expHalf(r) * TICK_DIV);
      check((r < 1 || r > RATE_MAX) ? "R8 rate clamp lit" : "R7 flash lit",
            highC, expHalf(r) * TICK_DIV);
    end

    // R9: duty change mid-period
    dimMode = 1'b1;
    dimDuty = 5'd5;
    restart();
    waitDark();
    countLow(lowC);
    check("R9 dark before change", lowC, 5 * TICK_DIV);
    dimDuty = 5'd15;
    countHigh(highC);
    check("R9 lit keeps old length", highC, 15 * TICK_DIV);
    countLow(lowC);
    check("R9 new duty next period", lowC, 15 * TICK_DIV);

    // R9: mode change mid-period
    dimDuty = 5'd5;
    restart();
    waitDark();
    countLow(lowC);
    dimMode = 1'b0;
    flashRate = 4'd5;
    countHigh(highC);
    check("R9 lit keeps dim length", highC, 15 * TICK_DIV);
    countLow(lowC);
    countHigh(highC);
    check("R9 flash dark next period", lowC, expHalf(5) * TICK_DIV);
    check("R9 flash lit next period", highC, expHalf(5) * TICK_DIV);

    // R2: disable while dark
    dimMode = 1'b1;
    dimDuty = 5'd18;
    restart();
    waitDark();
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 lit after disable", int'(blankN), 1);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!blankN) bad++;
    end
    check("R2 stays lit while disabled", bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule